// File: doc/BRIEF.md
# Single-Clock FIFO with Read Replay

This block is a first-in first-out buffer. It runs on one clock and its depth is set by a parameter. It uses standard read timing: a word appears on the output on the clock edge after a read is requested. The write, read and replay controls are all active low. Writes are refused while the buffer is full. Reads are refused while the registered empty indication is low.

The replay function makes data that has already been read available again. A replay request has two stages:

- The request edge moves the read pointer back to memory address zero and drives the empty indication low.
- The following edge recomputes the empty and full state from the write pointer and the rewound read pointer. From then on, reads return the stored words again, starting with the first word written since the last reset.

A request is honoured only when both read and write are idle and the buffer is inside a safe fill window. Any other request is dropped.

Two resets are provided. The master reset asserts asynchronously, is released through a two-stage synchronizer, and clears everything, including the output word. The partial reset is synchronous and clears only the pointers and the replay bookkeeping; the output word is kept.

Top module: `replay_fifo`

## Requirements
- R1: After master reset is released, `empty_n` is 0, `full` is 0 and `rdata` is 0.
- R2: A write (`wr_n`=0) while `full` is 0 stores `wdata`. A write while `full` is 1 is ignored: it stores nothing and `full` stays 1.
- R3: A read (`rd_n`=0) while `empty_n` is 1 places the oldest stored word on `rdata` after that edge. A read while `empty_n` is 0 leaves `rdata` unchanged.
- R4: `empty_n` rises on the edge that stores the first word. `full` rises on the edge that stores the DEPTH-th unread word.
- R5: `prst_n` sampled low clears occupancy, so `empty_n`=0 and `full`=0, and keeps `rdata` unchanged.
- R6: A replay request (`rt_n`=0 with `wr_n`=1 and `rd_n`=1, inside the window of R10) rewinds the read pointer to address zero and drives `empty_n` to 0 after that edge.
- R7: On the edge after a replay request, `empty_n` returns to 1, because at least two words are stored.
- R8: After replay, reads return the words in order, starting from the first word written since the last reset.
- R9: `rt_n`=0 while `wr_n` or `rd_n` is 0 is ignored: the write or read proceeds normally and no rewind happens.
- R10: A replay request is ignored unless at least two reads and at most DEPTH-2 writes have occurred since the last reset.
- R11: After replay, occupancy equals the number of words written since reset, and `full` rises once DEPTH words are held again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| wr_n | input | 1 | Write request, active low |
| rd_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Replay request, active low |
| wdata | input | DATA_W | Write word |
| rdata | output | DATA_W | Read word, registered |
| empty_n | output | 1 | 1 when words are readable; 0 when empty or during replay setup |
| full | output | 1 | 1 when DEPTH words are held |

## Verification
The embedded properties check these behaviours on every cycle:

- A refused write leaves the buffer full.
- An idle cycle keeps the output word.
- An accepted replay zeroes the read pointer and drops the empty indication, which comes back high on the next edge.
- A replay request that coincides with a read still advances the pointer.
- Accepted replays always fall inside the fill window, and occupancy never exceeds the depth.

Only the bench scenarios can show that replayed words come back in their original order. The same holds for replays refused by the window rules, the full flag recovering its level after a rewind, and the output word surviving a partial reset.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  // Per-cycle operations granted by the control logic
  typedef struct packed {
    logic wr_go;
    logic rd_go;
    logic rt_go;
  } rfifo_ops_t;
endpackage

// File: rtl/rfifo_store.sv
module rfifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_go,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_go) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_go) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata_q));
endmodule

// File: rtl/rfifo_rewind.sv
module rfifo_rewind #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prst_n,
  input  logic wr_n,
  input  logic rd_n,
  input  logic rt_n,
  input  logic wr_go,
  input  logic rd_go,
  output logic rt_go
);
  localparam logic [CW-1:0] WR_SAT = CW'(DEPTH);
  localparam logic [CW-1:0] WR_MAX = CW'(DEPTH - 2);

  logic [CW-1:0] wr_tot, wr_tot_nxt;
  logic [1:0]    rd_seen, rd_seen_nxt;
  logic          in_window;

  always_comb begin
    wr_tot_nxt  = wr_tot;
    rd_seen_nxt = rd_seen;
    if (wr_tot != WR_SAT)  wr_tot_nxt  = wr_tot + 1'b1;
    if (rd_seen != 2'd2)   rd_seen_nxt = rd_seen + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tot  <= '0;
      rd_seen <= '0;
    end else if (!prst_n) begin
      wr_tot  <= '0;
      rd_seen <= '0;
    end else begin
      if (wr_go) wr_tot  <= wr_tot_nxt;
      if (rd_go) rd_seen <= rd_seen_nxt;
    end
  end

  assign in_window = (rd_seen == 2'd2) && (wr_tot <= WR_MAX);
  assign rt_go     = !rt_n && wr_n && rd_n && in_window;
endmodule

// File: rtl/rfifo_ptrs.sv
module rfifo_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic          rt_go,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          empty_n,
  output logic          full
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [AW:0] wptr_x, rptr_x, wptr_nxt, rptr_nxt, cnt;
  logic        empty_n_q, empty_n_nxt;

  assign cnt   = wptr_x - rptr_x;
  assign full  = (cnt == CAP);
  assign wr_go = !wr_n && !full;
  assign rd_go = !rd_n && empty_n_q;

  always_comb begin
    wptr_nxt = wptr_x + {{AW{1'b0}}, wr_go};
    if (rt_go) rptr_nxt = '0;
    else       rptr_nxt = rptr_x + {{AW{1'b0}}, rd_go};
    empty_n_nxt = !rt_go && (wptr_nxt != rptr_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_x    <= '0;
      rptr_x    <= '0;
      empty_n_q <= 1'b0;
    end else if (!prst_n) begin
      wptr_x    <= '0;
      rptr_x    <= '0;
      empty_n_q <= 1'b0;
    end else begin
      if (wr_go)         wptr_x <= wptr_nxt;
      if (rd_go || rt_go) rptr_x <= rptr_nxt;
      empty_n_q <= empty_n_nxt;
    end
  end

  assign waddr   = wptr_x[AW-1:0];
  assign raddr   = rptr_x[AW-1:0];
  assign empty_n = empty_n_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n && rd_n && prst_n) |=> full);
  // R6
  rt_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_go && prst_n) |=> (rptr_x == '0 && !empty_n_q));
  // R7
  rt_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rt_go && prst_n) && prst_n) |=> empty_n_q);
  // R9
  rt_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n && rd_go && prst_n) |=> (rptr_x == $past(rptr_x) + 1'b1));
  // R10
  rt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_go |-> (wptr_x >= 2 && wptr_x <= CAP - 2));
  // R11
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              empty_n,
  output logic              full
);
  import rfifo_pkg::*;

  logic          rst_s0, rst_s1, rstn_i;
  rfifo_ops_t    ops;
  logic [AW-1:0] waddr, raddr;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rstn_i = rst_s1;

  rfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rstn_i), .prst_n(prst_n),
    .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .rt_go(ops.rt_go),
    .wr_go(ops.wr_go), .rd_go(ops.rd_go),
    .waddr(waddr), .raddr(raddr), .empty_n(empty_n), .full(full)
  );

  rfifo_rewind #(.DEPTH(DEPTH)) u_rewind (
    .clk(clk), .rst_n(rstn_i), .prst_n(prst_n),
    .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .wr_go(ops.wr_go), .rd_go(ops.rd_go), .rt_go(ops.rt_go)
  );

  rfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rstn_i),
    .wr_go(ops.wr_go), .waddr(waddr), .wdata(wdata),
    .rd_go(ops.rd_go), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/tb_replay_fifo.sv
`timescale 1ns/100ps
module tb_replay_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n, prst_n, wr_n, rd_n, rt_n;
  logic [DW-1:0] wdata, rdata;
  logic empty_n, full;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  replay_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .wr_n(wr_n), .rd_n(rd_n),
    .rt_n(rt_n), .wdata(wdata), .rdata(rdata), .empty_n(empty_n), .full(full)
  );

  typedef struct packed {
    logic wn, rn, tn;
    logic [7:0] d;
    logic e, f, cq;
    logic [7:0] q;
    logic [3:0] rq;
  } vec_t;

  // inputs (wr_n, rd_n, rt_n, wdata) -> expected after the edge
  localparam vec_t VEC [0:14] = '{
    '{1'b0,1'b1,1'b1,8'h11, 1'b1,1'b0,1'b0,8'h00, 4'd4}, // R4 first word
    '{1'b0,1'b1,1'b1,8'h22, 1'b1,1'b0,1'b0,8'h00, 4'd2},
    '{1'b0,1'b1,1'b1,8'h33, 1'b1,1'b0,1'b0,8'h00, 4'd2},
    '{1'b0,1'b1,1'b1,8'h44, 1'b1,1'b0,1'b0,8'h00, 4'd2},
    '{1'b1,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h11, 4'd3},
    '{1'b1,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h22, 4'd3},
    '{1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b1,8'h22, 4'd6}, // R6 setup
    '{1'b1,1'b1,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h22, 4'd7}, // R7 recover
    '{1'b1,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h11, 4'd8}, // R8 replay
    '{1'b1,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h22, 4'd8},
    '{1'b1,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,8'h33, 4'd8},
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'h44, 4'd9}, // R9 rt with read
    '{1'b0,1'b1,1'b0,8'h55, 1'b1,1'b0,1'b1,8'h44, 4'd9}, // R9 rt with write
    '{1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b1,8'h55, 4'd9},
    '{1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b1,8'h55, 4'd3}  // R3 read empty
  };

  task automatic check(input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
    end
  endtask

  // drive inputs away from the edge, pass one edge, settle
  task automatic cyc(input logic wn, input logic rn, input logic tn,
                     input logic [DW-1:0] d);
    wr_n = wn; rd_n = rn; rt_n = tn; wdata = d;
    @(posedge clk); #1;
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
  endtask

  task automatic preset();
    prst_n = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, '0);
    prst_n = 1'b1;
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prst_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "empty_n", empty_n, 0);
    check("R1", "full", full, 0);
    check("R1", "rdata", rdata, 0);

    for (int i = 0; i < 15; i++) begin
      cyc(VEC[i].wn, VEC[i].rn, VEC[i].tn, VEC[i].d);
      total++;
      if (empty_n !== VEC[i].e || full !== VEC[i].f ||
          (VEC[i].cq && rdata !== VEC[i].q)) begin
        bad++;
        $display("FAIL R%0d step %0d: got e=%b f=%b q=%0h expected e=%b f=%b q=%0h",
                 VEC[i].rq, i, empty_n, full, rdata, VEC[i].e, VEC[i].f, VEC[i].q);
      end
    end

    // R5 partial reset keeps output word, clears occupancy
    cyc(1'b0, 1'b1, 1'b1, 8'h77);
    preset();
    check("R5", "empty_n", empty_n, 0);
    check("R5", "full", full, 0);
    check("R5", "rdata", rdata, 8'h55);

    // R10 too few reads: one read then request
    cyc(1'b0, 1'b1, 1'b1, 8'hA0);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R5", "rdata after preset", rdata, 8'hA0);
    cyc(1'b0, 1'b1, 1'b1, 8'hA1);
    cyc(1'b0, 1'b1, 1'b1, 8'hA2);
    cyc(1'b1, 1'b1, 1'b0, 8'h00);
    check("R10", "empty_n after refused rt (few reads)", empty_n, 1);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R10", "rdata after refused rt (few reads)", rdata, 8'hA1);

    // R10 too many writes
    preset();
    for (int k = 0; k < 15; k++) cyc(1'b0, 1'b1, 1'b1, 8'hB0 + 8'(k));
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 8'h00);
    check("R10", "empty_n after refused rt (many writes)", empty_n, 1);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R10", "rdata after refused rt (many writes)", rdata, 8'hB2);
    // occupancy 12: fill to full
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b1, 8'hC0 + 8'(k));
    check("R4", "full at DEPTH-1", full, 0);
    cyc(1'b0, 1'b1, 1'b1, 8'hC3);
    check("R4", "full at DEPTH", full, 1);
    cyc(1'b0, 1'b1, 1'b1, 8'hEE);
    check("R2", "full after refused write", full, 1);
    begin
      int errs = 0;
      for (int k = 0; k < 16; k++) begin
        logic [7:0] e;
        e = (k < 12) ? 8'hB3 + 8'(k) : 8'hC0 + 8'(k - 12);
        cyc(1'b1, 1'b0, 1'b1, 8'h00);
        if (rdata !== e) errs++;
      end
      check("R2", "drain mismatches (no 0xEE stored)", errs, 0);
    end
    check("R2", "empty_n after drain", empty_n, 0);

    // R11 occupancy after replay
    preset();
    for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, 1'b1, 8'hD0 + 8'(k));
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 8'h00);
    check("R6", "empty_n in setup", empty_n, 0);
    check("R11", "full after rewind", full, 0);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    check("R7", "empty_n after setup", empty_n, 1);
    for (int k = 0; k < 9; k++) cyc(1'b0, 1'b1, 1'b1, 8'hE0 + 8'(k));
    check("R11", "full at 15 held", full, 0);
    cyc(1'b0, 1'b1, 1'b1, 8'hE9);
    check("R11", "full at 16 held", full, 1);
    begin
      int errs = 0;
      for (int k = 0; k < 16; k++) begin
        logic [7:0] e;
        e = (k < 6) ? 8'hD0 + 8'(k) : 8'hE0 + 8'(k - 6);
        cyc(1'b1, 1'b0, 1'b1, 8'h00);
        if (rdata !== e) errs++;
      end
      check("R8", "replay order mismatches", errs, 0);
    end
    check("R11", "empty_n after full drain", empty_n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule